// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block converts a configuration-space request, given as bus number, device number, function number, register offset and access size, into the steps a host needs to reach an external PCI bus through a memory-mapped window. For each legal request it loads a window-control value first. It then runs one 32-bit access, or two accesses for a partial write, on a downstream read/write port. It returns the read data or a completion with an error flag.

A request on bus zero becomes a type 0 cycle. The target slot is picked by a single set bit at position device + 16. Part of that bit pattern falls inside the window mask and is placed in the window value. The rest is placed in the access address. Requests on any other bus become type 1 cycles with the standard bus, device, function and register fields. The block itself aligns byte lanes on reads and merges byte lanes on sub-word writes. The host sees natural right-aligned data of 1, 2 or 4 bytes.

Only one request is handled at a time. A busy output covers the whole span from acceptance to response.

Top module: `pcicfg_xlate`

## Requirements
- R1: A request whose size is not 1, 2 or 4 (size field is a byte count) completes with rsp_err=1 and rsp_rdata=0, with no downstream access and no window write.
- R2: On bus 0 (type 0), the window value is CFG0_CODE | (S & WIN_MASK) and the access address is CFG_BASE | (S & ~WIN_MASK) | func<<8 | (offset & ~3), where S = 1 << (device + 16).
- R3: On bus 0, a device number of SLOTS (16) or more is rejected like R1.
- R4: During a type 0 access, exactly one bit in positions 31..16 is set across the window value's masked bits and the address's unmasked bits.
- R5: When cardbus_mode is 1, any device number of 2 or more is rejected like R1, on any bus.
- R6: On a nonzero bus (type 1), the window value is CFG1_CODE and the address is CFG_BASE | bus<<16 | device<<11 | func<<8 | (offset & ~3).
- R7: A read returns the downstream word shifted right by 8*(offset mod 4) and truncated to the size. Write responses and error responses return rsp_rdata=0.
- R8: A 1- or 2-byte write reads the word, replaces the byte lanes selected by 8*(offset mod 4) and the size, and writes the merged word back to the same address. Lanes above bit 31 are dropped.
- R9: A 4-byte write is one downstream write of req_wdata, with no read.
- R10: If ds_err is set with ds_ack, the response carries rsp_err=1. After an erroring read phase of a partial write, no write-back is issued.
- R11: req_busy is high from the cycle after acceptance until rsp_valid, and rsp_valid lasts one cycle. req_valid while busy is ignored.
- R12: win_we pulses for one cycle with the new win_value in the same cycle as the first downstream request. A rejected request leaves win_value unchanged. ds_req holds its address, write flag and data until ds_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cardbus_mode | input | 1 | Restricts targets to devices 0 and 1, sampled at acceptance |
| req_valid | input | 1 | Request strobe, taken when req_busy is low |
| req_busy | output | 1 | A request is in progress |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_off | input | OFF_W | Register byte offset |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Right-aligned write data |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 32 | Right-aligned read data |
| rsp_err | output | 1 | Request rejected or bus error |
| win_we | output | 1 | Window value was just loaded |
| win_value | output | 32 | Current window-control value |
| ds_req | output | 1 | Downstream access request |
| ds_we | output | 1 | Downstream write |
| ds_addr | output | 32 | Downstream word address |
| ds_wdata | output | 32 | Downstream write word |
| ds_ack | input | 1 | Downstream access done |
| ds_rdata | input | 32 | Downstream read word, valid with ds_ack |
| ds_err | input | 1 | Downstream bus error, valid with ds_ack |

## Verification
Two events can fall in the same cycle. The window load and the start of the first downstream access share one cycle. A bus error can also arrive on the same acknowledge that would otherwise end the read phase of a sub-word write. The bench covers the first case by sweeping every device, size and lane offset on both cycle types, then checks the loaded window value and the address the responder recorded against values it computes from the field formulas. It covers the second case by injecting an error on the read phase of a partial write, and judges it by the flagged response and an unchanged downstream write count.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

   localparam int BUS_W  = 8;
   localparam int DEV_W  = 5;
   localparam int FN_W   = 3;
   localparam int SIZE_W = 3;
   localparam int WORD_W = 32;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHK,
      ST_RD,
      ST_WR,
      ST_RSP
   } xl_state_t;

   function automatic logic size_legal(input logic [SIZE_W-1:0] sz);
      return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
   endfunction

endpackage

// File: rtl/pcicfg_route.sv
module pcicfg_route
   import pcicfg_pkg::*;
#(
   parameter int          SLOTS     = 16,
   parameter int          CB_DEVS   = 2,
   parameter int          OFF_W     = 8,
   parameter logic [31:0] WIN_MASK  = 32'hFC00_0000,
   parameter logic [31:0] CFG0_CODE = 32'h0000_0002,
   parameter logic [31:0] CFG1_CODE = 32'h0000_0003,
   parameter logic [31:0] CFG_BASE  = 32'h0C00_0000
) (
   input  logic [BUS_W-1:0]  bus,
   input  logic [DEV_W-1:0]  dev,
   input  logic [FN_W-1:0]   func,
   input  logic [OFF_W-1:0]  off,
   input  logic [SIZE_W-1:0] size,
   input  logic              cardbus,
   output logic              bad,
   output logic              type0,
   output logic [31:0]       win_code,
   output logic [31:0]       addr
);

   localparam int IDSEL_LSB = 16;

   generate
      if (SLOTS < 1 || SLOTS > 16) begin : g_bad_slots
         $error("SLOTS must be 1..16");
      end
      if (OFF_W < 2 || OFF_W > 8) begin : g_bad_off
         $error("OFF_W must be 2..8");
      end
      if ((CFG_BASE & ~WIN_MASK & 32'hFFFF_0000) != 32'h0) begin : g_bad_base
         $error("CFG_BASE overlaps slot-select bits outside the window");
      end
      if ((CFG0_CODE & WIN_MASK) != 32'h0) begin : g_bad_code
         $error("CFG0_CODE overlaps window-carried slot bits");
      end
   endgenerate

   logic [31:0] idsel;
   logic [7:0]  off8;
   logic        dev_hi_t0;
   logic        dev_hi_cb;

   assign type0 = (bus == '0);
   assign idsel = 32'd1 << ({1'b0, dev} + 6'(IDSEL_LSB));
   assign off8  = 8'(off) & 8'hFC;

   assign dev_hi_t0 = type0 && (32'(dev) >= SLOTS);
   assign dev_hi_cb = cardbus && (32'(dev) >= CB_DEVS);
   assign bad       = !size_legal(size) || dev_hi_t0 || dev_hi_cb;

   always_comb begin
      if (type0) begin
         win_code = CFG0_CODE | (idsel & WIN_MASK);
         addr     = CFG_BASE | (idsel & ~WIN_MASK) | {16'd0, 5'd0, func, off8};
      end else begin
         win_code = CFG1_CODE;
         addr     = CFG_BASE | {8'd0, bus, dev, func, off8};
      end
   end

endmodule

// File: rtl/pcicfg_lane.sv
module pcicfg_lane
   import pcicfg_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic [DW-1:0]     word,
   input  logic [1:0]        sh,
   input  logic [SIZE_W-1:0] size,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rd_val,
   output logic [DW-1:0]     merged
);

   localparam int LANES = DW / 8;

   generate
      if (DW != 32) begin : g_bad_dw
         $error("lane unit supports a 32-bit word only");
      end
   endgenerate

   logic [DW-1:0] word_sh;
   logic [DW-1:0] wdata_sh;

   assign word_sh  = word >> {sh, 3'b000};
   assign wdata_sh = wdata << {sh, 3'b000};

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      logic keep_rd;
      logic take_wr;
      assign keep_rd = (b < 32'(size));
      assign take_wr = (32'(sh) <= b) && (b < 32'(sh) + 32'(size));
      assign rd_val[8*b +: 8] = keep_rd ? word_sh[8*b +: 8]  : 8'h00;
      assign merged[8*b +: 8] = take_wr ? wdata_sh[8*b +: 8] : word[8*b +: 8];
   end

endmodule

// File: rtl/pcicfg_xlate.sv
module pcicfg_xlate
   import pcicfg_pkg::*;
#(
   parameter int          SLOTS     = 16,
   parameter int          CB_DEVS   = 2,
   parameter int          OFF_W     = 8,
   parameter logic [31:0] WIN_MASK  = 32'hFC00_0000,
   parameter logic [31:0] CFG0_CODE = 32'h0000_0002,
   parameter logic [31:0] CFG1_CODE = 32'h0000_0003,
   parameter logic [31:0] CFG_BASE  = 32'h0C00_0000,
   parameter logic [31:0] WIN_RST   = 32'h0000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cardbus_mode,
   input  logic              req_valid,
   output logic              req_busy,
   input  logic              req_write,
   input  logic [BUS_W-1:0]  req_bus,
   input  logic [DEV_W-1:0]  req_dev,
   input  logic [FN_W-1:0]   req_func,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [SIZE_W-1:0] req_size,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic [31:0]       rsp_rdata,
   output logic              rsp_err,
   output logic              win_we,
   output logic [31:0]       win_value,
   output logic              ds_req,
   output logic              ds_we,
   output logic [31:0]       ds_addr,
   output logic [31:0]       ds_wdata,
   input  logic              ds_ack,
   input  logic [31:0]       ds_rdata,
   input  logic              ds_err
);

   xl_state_t st;

   logic [BUS_W-1:0]  q_bus;
   logic [DEV_W-1:0]  q_dev;
   logic [FN_W-1:0]   q_func;
   logic [OFF_W-1:0]  q_off;
   logic [SIZE_W-1:0] q_size;
   logic [31:0]       q_wdata;
   logic              q_write;
   logic              q_cb;

   logic [31:0] wbuf;
   logic [31:0] rdata_q;
   logic [31:0] win_q;
   logic        err_q;
   logic        win_we_q;
   logic        touched;

   logic        rt_bad;
   logic        rt_type0;
   logic [31:0] rt_win;
   logic [31:0] rt_addr;
   logic [31:0] ln_rd;
   logic [31:0] ln_merged;

   pcicfg_route #(
      .SLOTS    (SLOTS),
      .CB_DEVS  (CB_DEVS),
      .OFF_W    (OFF_W),
      .WIN_MASK (WIN_MASK),
      .CFG0_CODE(CFG0_CODE),
      .CFG1_CODE(CFG1_CODE),
      .CFG_BASE (CFG_BASE)
   ) i_route (
      .bus     (q_bus),
      .dev     (q_dev),
      .func    (q_func),
      .off     (q_off),
      .size    (q_size),
      .cardbus (q_cb),
      .bad     (rt_bad),
      .type0   (rt_type0),
      .win_code(rt_win),
      .addr    (rt_addr)
   );

   pcicfg_lane #(.DW(32)) i_lane (
      .word  (ds_rdata),
      .sh    (q_off[1:0]),
      .size  (q_size),
      .wdata (q_wdata),
      .rd_val(ln_rd),
      .merged(ln_merged)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         q_bus    <= '0;
         q_dev    <= '0;
         q_func   <= '0;
         q_off    <= '0;
         q_size   <= '0;
         q_wdata  <= '0;
         q_write  <= 1'b0;
         q_cb     <= 1'b0;
         wbuf     <= '0;
         rdata_q  <= '0;
         win_q    <= WIN_RST;
         err_q    <= 1'b0;
         win_we_q <= 1'b0;
         touched  <= 1'b0;
      end else begin
         win_we_q <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  q_bus   <= req_bus;
                  q_dev   <= req_dev;
                  q_func  <= req_func;
                  q_off   <= req_off;
                  q_size  <= req_size;
                  q_wdata <= req_wdata;
                  q_write <= req_write;
                  q_cb    <= cardbus_mode;
                  err_q   <= 1'b0;
                  rdata_q <= '0;
                  touched <= 1'b0;
                  st      <= ST_CHK;
               end
            end
            ST_CHK: begin
               if (rt_bad) begin
                  err_q <= 1'b1;
                  st    <= ST_RSP;
               end else begin
                  win_q    <= rt_win;
                  win_we_q <= 1'b1;
                  if (q_write && q_size == 3'd4) begin
                     wbuf <= q_wdata;
                     st   <= ST_WR;
                  end else begin
                     st <= ST_RD;
                  end
               end
            end
            ST_RD: begin
               if (ds_ack) begin
                  if (ds_err) begin
                     err_q <= 1'b1;
                     st    <= ST_RSP;
                  end else if (!q_write) begin
                     rdata_q <= ln_rd;
                     st      <= ST_RSP;
                  end else begin
                     wbuf <= ln_merged;
                     st   <= ST_WR;
                  end
               end
            end
            ST_WR: begin
               if (ds_ack) begin
                  err_q <= ds_err;
                  st    <= ST_RSP;
               end
            end
            ST_RSP:  st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
         if (ds_req) touched <= 1'b1;
      end
   end

   assign req_busy  = (st != ST_IDLE);
   assign rsp_valid = (st == ST_RSP);
   assign rsp_rdata = rdata_q;
   assign rsp_err   = err_q;
   assign win_we    = win_we_q;
   assign win_value = win_q;
   assign ds_req    = (st == ST_RD) || (st == ST_WR);
   assign ds_we     = (st == ST_WR);
   assign ds_addr   = rt_addr;
   assign ds_wdata  = wbuf;

   // Completion frees the request port on the next cycle.
   assert_rsp_frees_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !req_busy && !rsp_valid);

   // The first downstream cycle of a request coincides with the window load.
   assert_win_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ds_req) |-> win_we);

   // A stalled downstream request keeps its command.
   assert_ds_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ds_req && !ds_ack |=> ds_req && $stable(ds_addr) && $stable(ds_we) && $stable(ds_wdata));

   // Rejected requests never touch the downstream port.
   assert_reject_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rt_bad |-> rsp_err && !touched);

   // Slot select is a single bit across window and address.
   assert_idsel_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ds_req && rt_type0 |->
         $countones(((win_value & WIN_MASK) | (ds_addr & ~WIN_MASK)) & 32'hFFFF_0000) == 1);

   // Sub-word write-back follows a read at the same address.
   assert_rmw_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ds_req && $rose(ds_we) && q_size != 3'd4 |-> $past(ds_req) && $stable(ds_addr));

   // A full-word write starts directly as a write.
   assert_full_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ds_req) && ds_we |-> q_size == 3'd4);

   // A failed read phase ends the downstream activity.
   assert_err_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ds_req && !ds_we && ds_ack && ds_err |=> !ds_req);

endmodule

// File: tb/test_pcicfg_xlate.sv
module test_pcicfg_xlate;

   localparam logic [31:0] MASK  = 32'hFC00_0000;
   localparam logic [31:0] C0    = 32'h0000_0002;
   localparam logic [31:0] C1    = 32'h0000_0003;
   localparam logic [31:0] BASE  = 32'h0C00_0000;
   localparam logic [31:0] WRST  = 32'h0000_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        cardbus_mode = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [7:0]  req_bus = '0;
   logic [4:0]  req_dev = '0;
   logic [2:0]  req_func = '0;
   logic [7:0]  req_off = '0;
   logic [2:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        req_busy, rsp_valid, rsp_err, win_we, ds_req, ds_we;
   logic [31:0] rsp_rdata, win_value, ds_addr, ds_wdata;
   logic        ds_ack, ds_err;
   logic [31:0] ds_rdata;

   logic        err_inject = 1'b0;
   int          rd_cnt, wr_cnt, win_cnt;
   logic [31:0] last_ra, last_wa, last_wd;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   pcicfg_xlate #(
      .SLOTS(16), .CB_DEVS(2), .OFF_W(8), .WIN_MASK(MASK),
      .CFG0_CODE(C0), .CFG1_CODE(C1), .CFG_BASE(BASE), .WIN_RST(WRST)
   ) i_pcicfg_xlate (
      .clk(clk), .rst_n(rst_n), .cardbus_mode(cardbus_mode),
      .req_valid(req_valid), .req_busy(req_busy), .req_write(req_write),
      .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
      .req_off(req_off), .req_size(req_size), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .win_we(win_we), .win_value(win_value),
      .ds_req(ds_req), .ds_we(ds_we), .ds_addr(ds_addr), .ds_wdata(ds_wdata),
      .ds_ack(ds_ack), .ds_rdata(ds_rdata), .ds_err(ds_err)
   );

   function automatic logic [31:0] pat(input logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ 32'h5A5A_C3C3;
   endfunction

   // Downstream responder: acknowledges one cycle after a request.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ds_ack <= 1'b0; ds_err <= 1'b0; ds_rdata <= '0;
         rd_cnt <= 0; wr_cnt <= 0; win_cnt <= 0;
         last_ra <= '0; last_wa <= '0; last_wd <= '0;
      end else begin
         ds_ack   <= ds_req && !ds_ack;
         ds_err   <= ds_req && !ds_ack && err_inject;
         ds_rdata <= pat(ds_addr);
         if (win_we) win_cnt <= win_cnt + 1;
         if (ds_req && ds_ack) begin
            if (ds_we) begin
               wr_cnt <= wr_cnt + 1; last_wa <= ds_addr; last_wd <= ds_wdata;
            end else begin
               rd_cnt <= rd_cnt + 1; last_ra <= ds_addr;
            end
         end
      end
   end

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", rq, act, exp);
      end
   endtask

   task automatic run_req(input bit wr, input logic [7:0] bus, input logic [4:0] dev,
                          input logic [2:0] fn, input logic [7:0] off,
                          input logic [2:0] sz, input logic [31:0] wd,
                          input bit cb, input bit einj, input bit poke);
      bit          bad, t0;
      logic [31:0] sel, ewin, eaddr, lm, shv, eword, w0;
      int          r0, wr0, wn0, n;
      bad = !(sz == 3'd1 || sz == 3'd2 || sz == 3'd4) ||
            (cb && dev >= 5'd2) || (bus == 8'd0 && dev >= 5'd16);
      t0  = (bus == 8'd0);
      sel = (dev < 5'd16) ? (32'd1 << (dev + 5'd16)) : 32'd0;
      ewin  = t0 ? (C0 | (sel & MASK)) : C1;
      eaddr = t0 ? (BASE | (sel & ~MASK) | (32'(fn) << 8) | 32'(off & 8'hFC))
                 : (BASE | (32'(bus) << 16) | (32'(dev) << 11) | (32'(fn) << 8) | 32'(off & 8'hFC));
      lm  = (sz == 3'd1) ? 32'hFF : (sz == 3'd2) ? 32'hFFFF : 32'hFFFF_FFFF;
      shv = 32'(off[1:0]) * 8;
      @(negedge clk);
      w0 = win_value; r0 = rd_cnt; wr0 = wr_cnt; wn0 = win_cnt;
      err_inject = einj;
      cardbus_mode = cb; req_write = wr; req_bus = bus; req_dev = dev;
      req_func = fn; req_off = off; req_size = sz; req_wdata = wd; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R11 busy after accept", 32'(req_busy), 32'd1);
      if (poke) begin
         req_valid = 1'b1; req_write = 1'b1; req_size = 3'd4; req_bus = 8'd9;
         @(negedge clk);
         @(negedge clk);
         req_valid = 1'b0;
      end
      n = 0;
      while (!rsp_valid && n < 60) begin
         @(negedge clk);
         n++;
      end
      chk("R11 response arrives", 32'(rsp_valid), 32'd1);
      if (bad) begin
         chk("R1 R3 R5 reject err", 32'(rsp_err), 32'd1);
         chk("R1 R3 R5 reject rdata", rsp_rdata, 32'd0);
         chk("R1 reject no access", 32'(rd_cnt - r0 + wr_cnt - wr0), 32'd0);
         chk("R12 reject keeps window", win_value, w0);
         chk("R12 reject no window load", 32'(win_cnt - wn0), 32'd0);
      end else begin
         chk("R2 R6 window value", win_value, ewin);
         chk("R12 one window load", 32'(win_cnt - wn0), 32'd1);
         if (!wr) begin
            eword = pat(eaddr) >> shv;
            chk("R2 R6 read address", last_ra, eaddr);
            chk("R10 read err flag", 32'(rsp_err), 32'(einj));
            chk("R7 read data", rsp_rdata, einj ? 32'd0 : (eword & lm));
            chk("R7 read count", 32'(rd_cnt - r0), 32'd1);
            chk("R11 no write from ignored request", 32'(wr_cnt - wr0), 32'd0);
         end else if (sz == 3'd4) begin
            chk("R9 no read", 32'(rd_cnt - r0), 32'd0);
            chk("R9 one write", 32'(wr_cnt - wr0), 32'd1);
            chk("R9 write data", last_wd, wd);
            chk("R9 write address", last_wa, eaddr);
            chk("R10 full write err", 32'(rsp_err), 32'(einj));
            chk("R7 write rdata zero", rsp_rdata, 32'd0);
         end else begin
            chk("R8 one read", 32'(rd_cnt - r0), 32'd1);
            chk("R10 partial write err", 32'(rsp_err), 32'(einj));
            if (einj) begin
               chk("R10 no write-back", 32'(wr_cnt - wr0), 32'd0);
            end else begin
               eword = (pat(eaddr) & ~(lm << shv)) | ((wd & lm) << shv);
               chk("R8 one write", 32'(wr_cnt - wr0), 32'd1);
               chk("R8 same address", last_wa, last_ra);
               chk("R8 merged word", last_wd, eword);
               chk("R2 R6 rmw address", last_wa, eaddr);
            end
         end
      end
      @(negedge clk);
      chk("R11 single-cycle rsp", 32'(rsp_valid), 32'd0);
      chk("R11 idle after rsp", 32'(req_busy), 32'd0);
      err_inject = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 190000 && !done; i++) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 reset busy", 32'(req_busy), 32'd0);
      chk("R11 reset rsp", 32'(rsp_valid), 32'd0);
      chk("R12 reset ds_req", 32'(ds_req), 32'd0);
      chk("R12 reset window", win_value, WRST);

      // Reads: both cycle types, every device, every size code, lane offsets.
      for (int b = 0; b < 2; b++)
         for (int d = 0; d < 32; d++)
            for (int s = 0; s < 8; s++)
               for (int o = 0; o < 6; o++) begin
                  logic [7:0] ov;
                  ov = (o < 4) ? 8'(o) : (o == 4) ? 8'h3D : 8'hFE;
                  run_req(1'b0, (b == 0) ? 8'd0 : 8'd5, 5'(d), 3'(d % 8), ov,
                          3'(s), 32'd0, 1'b0, 1'b0, 1'b0);
               end

      // Writes: partial and full, every lane offset.
      for (int b = 0; b < 2; b++)
         for (int d = 0; d < 6; d++)
            for (int s = 1; s < 5; s++)
               for (int o = 0; o < 8; o++) begin
                  logic [4:0] dv;
                  dv = (d == 0) ? 5'd0 : (d == 1) ? 5'd3 : (d == 2) ? 5'd9 :
                       (d == 3) ? 5'd12 : (d == 4) ? 5'd15 : 5'd20;
                  run_req(1'b1, (b == 0) ? 8'd0 : 8'd2, dv, 3'(o), 8'(o + 8 * d),
                          3'(s), 32'hC3A5_0000 ^ (32'(o) * 32'h0101_0111) ^ 32'(d),
                          1'b0, 1'b0, 1'b0);
               end

      // R5 cardbus restriction on both cycle types.
      for (int b = 0; b < 2; b++)
         for (int d = 0; d < 4; d++)
            run_req(1'b0, 8'(b * 7), 5'(d), 3'd1, 8'h10, 3'd4, 32'd0, 1'b1, 1'b0, 1'b0);

      // R10 downstream errors.
      run_req(1'b0, 8'd0, 5'd4, 3'd0, 8'h02, 3'd2, 32'd0, 1'b0, 1'b1, 1'b0);
      run_req(1'b1, 8'd0, 5'd4, 3'd0, 8'h01, 3'd1, 32'hAB, 1'b0, 1'b1, 1'b0);
      run_req(1'b1, 8'd3, 5'd1, 3'd2, 8'h22, 3'd2, 32'h1234, 1'b0, 1'b1, 1'b0);
      run_req(1'b1, 8'd3, 5'd1, 3'd2, 8'h20, 3'd4, 32'hFEED_F00D, 1'b0, 1'b1, 1'b0);

      // R11 requests during busy are ignored.
      run_req(1'b0, 8'd0, 5'd11, 3'd3, 8'h07, 3'd1, 32'd0, 1'b0, 1'b0, 1'b1);
      run_req(1'b0, 8'd4, 5'd30, 3'd7, 8'h41, 3'd2, 32'd0, 1'b0, 1'b0, 1'b1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule